// File: doc/BRIEF.md
# JTAG Debug Bus Access Bridge

This block provides the scan data registers through which a JTAG host reaches an on-chip debug register bus. A TAP controller outside the block supplies the current instruction and one-cycle capture, shift and update strobes, all synchronous to the block clock. The bridge then selects the matching data register, shifts it least-significant bit first between the serial input and the serial output, and turns the capture and update events into requests on a single-outstanding debug bus that uses a request/acknowledge handshake.

A debug access takes two instructions. The first loads an 8-bit register address. The second either reads the register at that address, or writes new content while the old content is shifted out in the same scan. The read behind a scan starts at capture, and the scan shifts out the data that the acknowledge returns. A write starts at update. A fixed identification register and a one-bit bypass register complete the set of data registers.

Top module: `dmi_jtag_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `dmi_req` and `dmi_we` are 0, `dmi_addr` is 0 and `tdo` is 0.
- R2: Instruction code 1 selects a 32-bit identification register. Capture loads 0x000018FF, and `tdo` presents bit 0 first, then one higher bit per shift.
- R3: Instruction code 8 selects an 8-bit address register. Capture loads the latched address, which therefore shifts out as the previous value. Update latches the 8 shifted-in bits, with the first bit shifted in landing in the LSB, as the debug bus address.
- R4: Instruction code 9 selects a 64-bit read register. Capture issues a read request (`dmi_we`=0) at the latched address. The `dmi_rdata` returned with `dmi_ack` is loaded and then shifted out LSB first.
- R5: Instruction code 10 selects a 64-bit write-read register. Capture reads the latched address as in R4, so the scan shifts out the old content. Update then issues a write request (`dmi_we`=1) that carries the 64 shifted-in bits as `dmi_wdata`.
- R6: Every other instruction code selects a 1-bit bypass register. It captures 0, and `tdi` appears on `tdo` after one shift.
- R7: A request stays asserted with `dmi_addr`, `dmi_we` and `dmi_wdata` unchanged until `dmi_ack`, and it drops in the cycle after `dmi_ack`.
- R8: An update under the read instruction (code 9) issues no bus request and leaves the latched address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, shared with the TAP strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 4 | Current decoded instruction |
| capture_dr | input | 1 | One-cycle Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR enable, one bit per cycle |
| update_dr | input | 1 | One-cycle Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the selected register) |
| dmi_req | output | 1 | Debug bus request |
| dmi_we | output | 1 | Write flag of the request |
| dmi_addr | output | 8 | Request address |
| dmi_wdata | output | 64 | Write data |
| dmi_rdata | input | 64 | Read data, valid with dmi_ack |
| dmi_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
The assertions assume a well-behaved TAP and bus partner. `ir` stays constant from capture through update, `dmi_ack` is raised only while `dmi_req` is high and lasts one cycle, and no capture or update arrives while a request is still pending. The bench drives the strobes one scan at a time. Before it shifts, and again after each update, it waits for `dmi_req` to fall. Its bus model answers each request after a latency of zero to two cycles, so the handshake is exercised at several latencies.

// File: rtl/dmi_bridge_pkg.sv
package dmi_bridge_pkg;
  typedef enum logic [2:0] {
    SEL_BYPASS,
    SEL_IDCODE,
    SEL_ADDR,
    SEL_READ,
    SEL_WRRD
  } dr_sel_e;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_RD,
    BUS_WR
  } bus_st_e;
endpackage

// File: rtl/dmi_dr_chain.sv
module dmi_dr_chain #(
  parameter int W     = 64,
  parameter int LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [W-1:0]     cap_val,
  input  logic             load_en,
  input  logic [W-1:0]     load_val,
  input  logic             shift_en,
  input  logic             tdi,
  input  logic [LEN_W-1:0] len,
  output logic [W-1:0]     dr_q,
  output logic             tdo
);
  logic [W-1:0] sr_q, sr_d, shifted;

  always_comb begin
    shifted = {1'b0, sr_q[W-1:1]};
    for (int i = 0; i < W; i++) begin
      if (i == int'(len) - 1) shifted[i] = tdi;
      else if (i >= int'(len)) shifted[i] = 1'b0;
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (load_en)       sr_d = load_val;
    else if (cap_en)   sr_d = cap_val;
    else if (shift_en) sr_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (load_en || cap_en || shift_en) sr_q <= sr_d;
  end

  assign dr_q = sr_q;
  assign tdo  = sr_q[0];
endmodule

// File: rtl/dmi_req_ctrl.sv
module dmi_req_ctrl
  import dmi_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dmi_ack,
  output logic              dmi_req,
  output logic              dmi_we,
  output logic [ADDR_W-1:0] dmi_addr,
  output logic [DATA_W-1:0] dmi_wdata,
  output logic              rd_done
);
  bus_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              start;

  assign start = (st_q == BUS_IDLE) && (rd_start || wr_start);

  always_comb begin
    st_d = st_q;
    case (st_q)
      BUS_IDLE: if (rd_start) st_d = BUS_RD;
                else if (wr_start) st_d = BUS_WR;
      BUS_RD, BUS_WR: if (dmi_ack) st_d = BUS_IDLE;
      default: st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BUS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (start) addr_q <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdata_q <= '0;
    else if (start && !rd_start) wdata_q <= wr_data;
  end

  assign dmi_req   = (st_q != BUS_IDLE);
  assign dmi_we    = (st_q == BUS_WR);
  assign dmi_addr  = addr_q;
  assign dmi_wdata = wdata_q;
  assign rd_done   = (st_q == BUS_RD) && dmi_ack;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_req && !dmi_ack |=> dmi_req && $stable(dmi_addr) && $stable(dmi_we) && $stable(dmi_wdata));
  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_req && dmi_ack |=> !dmi_req);
endmodule

// File: rtl/dmi_jtag_bridge.sv
module dmi_jtag_bridge
  import dmi_bridge_pkg::*;
#(
  parameter int          IR_W      = 4,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 64,
  parameter int          ID_W      = 32,
  parameter logic [31:0] ID_VALUE  = 32'h0000_18FF,
  parameter int          CODE_ID   = 1,
  parameter int          CODE_ADDR = 8,
  parameter int          CODE_READ = 9,
  parameter int          CODE_WRRD = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              dmi_req,
  output logic              dmi_we,
  output logic [ADDR_W-1:0] dmi_addr,
  output logic [DATA_W-1:0] dmi_wdata,
  input  logic [DATA_W-1:0] dmi_rdata,
  input  logic              dmi_ack
);
  localparam int LEN_W = $clog2(DATA_W + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  dr_sel_e           sel;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] cap_val, dr_q;
  logic [LEN_W-1:0]  len;
  logic              rd_start, wr_start, rd_done, addr_upd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    if (ir == IR_W'(CODE_ID))        sel = SEL_IDCODE;
    else if (ir == IR_W'(CODE_ADDR)) sel = SEL_ADDR;
    else if (ir == IR_W'(CODE_READ)) sel = SEL_READ;
    else if (ir == IR_W'(CODE_WRRD)) sel = SEL_WRRD;
    else                             sel = SEL_BYPASS;
  end

  always_comb begin
    cap_val = '0;
    len     = LEN_W'(1);
    case (sel)
      SEL_IDCODE: begin cap_val = DATA_W'(ID_VALUE[ID_W-1:0]); len = LEN_W'(ID_W); end
      SEL_ADDR:   begin cap_val = DATA_W'(addr_q); len = LEN_W'(ADDR_W); end
      SEL_READ,
      SEL_WRRD:   begin cap_val = hold_q; len = LEN_W'(DATA_W); end
      default:    begin cap_val = '0; len = LEN_W'(1); end
    endcase
  end

  assign rd_start = capture_dr && (sel == SEL_READ || sel == SEL_WRRD);
  assign wr_start = update_dr && (sel == SEL_WRRD);
  assign addr_upd = update_dr && (sel == SEL_ADDR);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) addr_q <= '0;
    else if (addr_upd) addr_q <= dr_q[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hold_q <= '0;
    else if (rd_done) hold_q <= dmi_rdata;
  end

  dmi_dr_chain #(.W(DATA_W), .LEN_W(LEN_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (capture_dr),
    .cap_val  (cap_val),
    .load_en  (rd_done),
    .load_val (dmi_rdata),
    .shift_en (shift_dr),
    .tdi      (tdi),
    .len      (len),
    .dr_q     (dr_q),
    .tdo      (tdo)
  );

  dmi_req_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_start  (rd_start),
    .wr_start  (wr_start),
    .addr      (addr_q),
    .wr_data   (dr_q),
    .dmi_ack   (dmi_ack),
    .dmi_req   (dmi_req),
    .dmi_we    (dmi_we),
    .dmi_addr  (dmi_addr),
    .dmi_wdata (dmi_wdata),
    .rd_done   (rd_done)
  );

  assert_idcode_lsb_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    capture_dr && sel == SEL_IDCODE && !dmi_ack |=> tdo == ID_VALUE[0]);
  assert_bypass_zero_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    capture_dr && sel == SEL_BYPASS && !dmi_ack |=> !tdo);
  assert_read_flag_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    capture_dr && sel == SEL_READ && !dmi_req |=> dmi_req && !dmi_we);
  assert_no_req_upd_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    update_dr && sel == SEL_READ && !dmi_req |=> !dmi_req);
endmodule

// File: tb/tb_dmi_jtag_bridge.sv
module tb_dmi_jtag_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ir;
  logic        capture_dr, shift_dr, update_dr, tdi;
  logic        tdo, dmi_req, dmi_we, dmi_ack;
  logic [7:0]  dmi_addr;
  logic [63:0] dmi_wdata, dmi_rdata;

  int n_tests = 0, n_fail = 0;
  int wr_count = 0, rd_count = 0;
  int lat = 0, lat_cnt = 0, viol = 0;
  logic [63:0] mem [256];
  logic [7:0]  cur_addr;

  always #10 clk = ~clk;

  dmi_jtag_bridge dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .dmi_req(dmi_req), .dmi_we(dmi_we),
    .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata), .dmi_ack(dmi_ack)
  );

  function automatic logic [63:0] init_val(int i);
    return 64'hC3A5_0000_0000_0000 ^ (64'(i) * 64'h0001_0203_0405);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus partner: answers after 0..2 cycles
  always @(negedge clk) begin
    if (dmi_ack) dmi_ack = 1'b0;
    else if (rst_n && dmi_req) begin
      if (lat_cnt >= lat) begin
        dmi_ack = 1'b1;
        if (dmi_we) begin mem[dmi_addr] = dmi_wdata; wr_count++; end
        else begin dmi_rdata = mem[dmi_addr]; rd_count++; end
        lat_cnt = 0;
        lat = (lat + 1) % 3;
      end else lat_cnt++;
    end
  end

  // handshake monitor for R7
  logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [7:0]  p_addr = '0;
  logic [63:0] p_wdata = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (p_req && !p_ack && !(dmi_req && dmi_addr == p_addr && dmi_we == p_we && dmi_wdata == p_wdata))
        viol++;
      if (p_req && p_ack && dmi_req) viol++;
    end
    p_req = dmi_req; p_ack = dmi_ack; p_we = dmi_we; p_addr = dmi_addr; p_wdata = dmi_wdata;
  end

  task automatic scan(input logic [3:0] code, input int len, input logic [63:0] din,
                      output logic [63:0] dout);
    ir = code;
    dout = '0;
    @(negedge clk) capture_dr = 1'b1;
    @(negedge clk) capture_dr = 1'b0;
    while (dmi_req) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shift_dr = 1'b1;
      @(negedge clk);
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    @(negedge clk) update_dr = 1'b0;
    while (dmi_req) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [63:0] got, nv;
    int wc, rc;
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    rst_n = 1'b0; ir = '0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    dmi_ack = 1'b0; dmi_rdata = '0; cur_addr = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!dmi_req && !dmi_we, "R1 req/we in reset", {62'b0, dmi_req, dmi_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!dmi_req && !dmi_we, "R1 req/we after reset", {62'b0, dmi_req, dmi_we}, 0);
    check(dmi_addr == 0, "R1 addr after reset", 64'(dmi_addr), 0);
    check(tdo == 0, "R1 tdo after reset", 64'(tdo), 0);

    // R2 identification
    scan(4'd1, 32, '0, got);
    check(got == 64'h18FF, "R2 idcode", got, 64'h18FF);

    // R3 / R4: address sweep with reads
    for (int a = 0; a < 20; a++) begin
      logic [7:0] na;
      na = (a < 16) ? 8'(a) : 8'(255 - a);
      scan(4'd8, 8, 64'(na), got);
      check(got == 64'(cur_addr), "R3 old address out", got, 64'(cur_addr));
      cur_addr = na;
      rc = rd_count;
      scan(4'd9, 64, 64'hFFFF_0000_FFFF_0000, got);
      check(got == mem[cur_addr], "R4 read data", got, mem[cur_addr]);
      check(rd_count == rc + 1, "R4 one read request", 64'(rd_count - rc), 1);
    end

    // R5: write-read returns old content, stores new
    for (int a = 0; a < 8; a++) begin
      logic [63:0] old;
      cur_addr = 8'(a * 37 + 3);
      scan(4'd8, 8, 64'(cur_addr), got);
      old = mem[cur_addr];
      nv = 64'hFEEF_0000_0000_0101 ^ (64'(a) << (a * 7));
      wc = wr_count;
      scan(4'd10, 64, nv, got);
      check(got == old, "R5 old content out", got, old);
      check(wr_count == wc + 1 && mem[cur_addr] == nv, "R5 write stored", mem[cur_addr], nv);
      scan(4'd9, 64, '0, got);
      check(got == nv, "R5 readback", got, nv);
    end

    // R6: bypass for all other codes
    for (int c = 0; c < 16; c++) begin
      if (c != 1 && c != 8 && c != 9 && c != 10) begin
        rc = rd_count; wc = wr_count;
        scan(4'(c), 3, 64'b101, got);
        check(got == 64'b010, "R6 bypass path", got, 64'b010);
        scan(4'(c), 3, 64'b010, got);
        check(got == 64'b100, "R6 bypass path 2", got, 64'b100);
        check(rd_count == rc && wr_count == wc, "R6 no bus traffic", 64'(rd_count - rc), 0);
      end
    end

    // R8: update under read has no side effect
    cur_addr = 8'h05;
    scan(4'd8, 8, 64'h05, got);
    wc = wr_count;
    scan(4'd9, 64, 64'h0000_0000_0000_0A0A, got);
    check(wr_count == wc, "R8 no write on read update", 64'(wr_count - wc), 0);
    scan(4'd8, 8, 64'h05, got);
    check(got == 64'h05, "R8 address kept", got, 64'h05);

    // R7 handshake over the whole run
    check(viol == 0, "R7 request hold/drop", 64'(viol), 0);
    finish_run();
  end
endmodule